// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Engine

This block is the target side of a two-wire serial EEPROM. It runs on the system clock, takes already-sampled clock and data lines from the bus, and pulls the data line low through an open-drain output enable. It recognises start and stop conditions and compares the device-select byte. It acknowledges each byte it accepts. A 16-bit word pointer is loaded over two address bytes. The block then serves byte writes, page writes of up to 128 bytes, reads at the current pointer, random reads and sequential reads.

Write data goes into a 128-byte staging page with one valid flag per byte. A stop that ends a write with at least one complete data byte starts a self-timed busy period. That period is a programmable count of system clocks, followed by a commit pass that copies only the flagged bytes into the array. While busy, the block ignores the bus completely. A host can therefore poll with device-select bytes until one is acknowledged. The array holds 2^MEM_AW bytes and aliases the 16-bit address onto its low MEM_AW bits. Set MEM_AW to 16 for the full 64 KiB.

Top module: `ee2w_target`

## Requirements
- R1: While reset is asserted and right after it, sda_oe_o is 0 and the word pointer is 0x0000. Array contents survive a reset, so a current-address read after reset returns the byte stored at 0x0000.
- R2: SDA falling while SCL is high is a start and puts the block into device-select reception from any state, including in the middle of an address. SDA rising while SCL is high is a stop and returns the block to idle. After a stop, bytes are not acknowledged until the next start.
- R3: The device-select byte is bits [7:4] = 1010, bits [3:1] = 000, and bit 0 = R/W with 1 meaning read. When it matches, the block holds sda_oe_o high through the ninth SCL high phase. On a mismatch it gives no acknowledge and ignores the bus until the next start.
- R4: After a write select, two address bytes follow, high byte first. Each one is acknowledged, and together they set the 16-bit word pointer.
- R5: Each received data byte is acknowledged. After the stop and the busy period, a byte write reads back at its address.
- R6: During a write only pointer bits [6:0] advance, so the 128-byte page wraps onto itself. With more than 128 bytes, the later bytes overwrite the earlier ones, and the next page is untouched.
- R7: A partial page write changes only the offsets it received. All other bytes of the page keep their values.
- R8: A stop after a write with at least one complete data byte starts a busy period lasting WR_CYCLES + 128 system clocks. During it, device-select bytes are not acknowledged. Once it ends, they are acknowledged again.
- R9: A stop after a write that carried no complete data byte starts no busy period, and the next device-select byte is acknowledged at once.
- R10: The pointer keeps the last accessed address plus one, where write increments follow R6. A current-address read (select with R/W = 1 right after a start) returns the byte at that pointer.
- R11: In a read the pointer advances by one for every byte sent, over all 16 bits, wrapping from 0xFFFF to 0x0000. Sending continues while the host acknowledges and stops on a host NACK.
- R12: A random read is a write select, two address bytes, a repeated start, and a read select. It returns data starting at the loaded address.
- R13: A byte cut short by a start or a stop is discarded. A repeated start discards the staged write data, so nothing is written and no busy period follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line (wired level) |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
Two pairs of events can land together. The first is a stop that both closes a data transfer and must decide whether to launch the write timer, even when it cuts a byte short. The bench provokes this with a stop after three bits of a second byte. It then judges by reading back both the completed byte and its untouched neighbour, and by whether the next poll is refused. The second is the read pointer's increment coinciding with the 0xFFFF rollover, which a sequential read across that boundary exposes against the bench's reference array. Acknowledge polls are timed from the stop to measure the busy window against WR_CYCLES + 128.

// File: rtl/ee2w_pkg.sv
`timescale 1ns/1ps
package ee2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AH, ST_AL, ST_WD, ST_RD
  } ee_st_e;

  localparam logic [6:0] DEV_SEL = 7'b1010000;
endpackage

// File: rtl/ee2w_bus_cond.sv
`timescale 1ns/1ps
module ee2w_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ee2w_store.sv
`timescale 1ns/1ps
module ee2w_store #(
  parameter int MEM_AW    = 11,
  parameter int PAGE_AW   = 7,
  parameter int WR_CYCLES = 1000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      stg_we_i,
  input  logic [PAGE_AW-1:0]        stg_idx_i,
  input  logic [7:0]                stg_data_i,
  input  logic                      clear_i,
  input  logic                      commit_i,
  input  logic [MEM_AW-PAGE_AW-1:0] page_i,
  input  logic [MEM_AW-1:0]         rd_addr_i,
  output logic [7:0]                rd_data_o,
  output logic                      busy_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PG    = 1 << PAGE_AW;
  localparam int TW    = $clog2(WR_CYCLES + 1);
  localparam int PGN_W = MEM_AW - PAGE_AW;

  logic [7:0]         mem [DEPTH];
  logic [7:0]         stg [PG];
  logic [PG-1:0]      vld;
  logic [TW-1:0]      tmr_q;
  logic               walk_q;
  logic [PAGE_AW-1:0] widx_q;
  logic [PGN_W-1:0]   wpage_q;
  logic [MEM_AW-1:0]  waddr;

  assign waddr  = {wpage_q, widx_q};
  assign busy_o = (tmr_q != '0) || walk_q;

  // timer phase, then one staged byte per clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q   <= '0;
      walk_q  <= 1'b0;
      widx_q  <= '0;
      wpage_q <= '0;
    end else if (commit_i) begin
      tmr_q   <= TW'(WR_CYCLES);
      wpage_q <= page_i;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - TW'(1);
      if (tmr_q == TW'(1)) begin
        walk_q <= 1'b1;
        widx_q <= '0;
      end
    end else if (walk_q) begin
      widx_q <= widx_q + PAGE_AW'(1);
      if (&widx_q) walk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (stg_we_i) stg[stg_idx_i] <= stg_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (walk_q && vld[widx_q]) mem[waddr] <= stg[widx_q];
  end

  for (genvar g = 0; g < PG; g++) begin : g_vld
    logic v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        v_q <= 1'b0;
      else if (clear_i)                                   v_q <= 1'b0;
      else if (stg_we_i && stg_idx_i == PAGE_AW'(g))      v_q <= 1'b1;
      else if (walk_q && widx_q == PAGE_AW'(g))           v_q <= 1'b0;
    end
    assign vld[g] = v_q;
  end

  assign rd_data_o = mem[rd_addr_i];

  // R8
  commit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !busy_o);
  // R8
  commit_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> busy_o);
endmodule

// File: rtl/ee2w_target.sv
`timescale 1ns/1ps
module ee2w_target import ee2w_pkg::*; #(
  parameter int MEM_AW    = 11,
  parameter int WR_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int ADDR_W  = 16;
  localparam int PAGE_AW = 7;

  ee_st_e            st_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic [6:0]        tx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              oe_q, ack_q, hack_q, data_q;
  logic              scl_rise, scl_fall, start, stop;
  logic              busy, byte_end, stg_we, clear, commit;
  logic [7:0]        rd_data;

  ee2w_bus_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  assign byte_end = scl_fall && cnt_q == 4'd8 && !ack_q &&
                    st_q != ST_IDLE && st_q != ST_RD;
  assign stg_we   = byte_end && st_q == ST_WD && !busy;
  assign clear    = start && !busy;
  assign commit   = stop && !busy && data_q;

  ee2w_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .stg_we_i(stg_we), .stg_idx_i(ptr_q[PAGE_AW-1:0]), .stg_data_i(sh_q),
    .clear_i(clear), .commit_i(commit), .page_i(ptr_q[MEM_AW-1:PAGE_AW]),
    .rd_addr_i(ptr_q[MEM_AW-1:0]), .rd_data_o(rd_data), .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0; ptr_q <= '0;
      oe_q <= 1'b0; ack_q <= 1'b0; hack_q <= 1'b0; data_q <= 1'b0;
    end else if (busy || stop) begin
      st_q <= ST_IDLE; oe_q <= 1'b0; ack_q <= 1'b0; data_q <= 1'b0;
    end else if (start) begin
      st_q <= ST_DEV; cnt_q <= '0; oe_q <= 1'b0; ack_q <= 1'b0; data_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: ;
        ST_RD: begin
          if (scl_rise && cnt_q == 4'd9) hack_q <= ~sda_i;
          if (scl_fall) begin
            if (cnt_q < 4'd8) begin
              oe_q  <= ~tx_q[6];
              tx_q  <= {tx_q[5:0], 1'b0};
              cnt_q <= cnt_q + 4'd1;
            end else if (cnt_q == 4'd8) begin
              oe_q  <= 1'b0;
              ptr_q <= ptr_q + 16'd1;   // full-width wrap on reads
              cnt_q <= 4'd9;
            end else if (hack_q) begin
              tx_q  <= rd_data[6:0];
              oe_q  <= ~rd_data[7];
              cnt_q <= 4'd1;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: begin
          if (scl_rise && cnt_q < 4'd8 && !ack_q) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end
          if (scl_fall && ack_q) begin
            ack_q <= 1'b0;
            oe_q  <= 1'b0;
            cnt_q <= '0;
          end
          if (byte_end) begin
            ack_q <= 1'b1;
            oe_q  <= 1'b1;
            case (st_q)
              ST_DEV: begin
                if (sh_q[7:1] != DEV_SEL) begin
                  st_q <= ST_IDLE; ack_q <= 1'b0; oe_q <= 1'b0;
                end else if (sh_q[0]) begin
                  // own ack doubles as the host ack that loads the first byte
                  st_q <= ST_RD; ack_q <= 1'b0; cnt_q <= 4'd9; hack_q <= 1'b1;
                end else begin
                  st_q <= ST_AH;
                end
              end
              ST_AH: begin ptr_q[15:8] <= sh_q; st_q <= ST_AL; end
              ST_AL: begin ptr_q[7:0]  <= sh_q; st_q <= ST_WD; end
              default: begin
                ptr_q[PAGE_AW-1:0] <= ptr_q[PAGE_AW-1:0] + PAGE_AW'(1);
                data_q <= 1'b1;
              end
            endcase
          end
        end
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  // R8
  oe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);
  // R2
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_i));
  // R6
  wr_page_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WD && $past(st_q) == ST_WD) |-> ptr_q[15:7] == $past(ptr_q[15:7]));
  // R3
  dev_nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && st_q == ST_DEV && sh_q[7:1] != DEV_SEL) |=> !sda_oe_o);
endmodule

// File: tb/sim_ee2w_target.sv
`timescale 1ns/1ps
module sim_ee2w_target;
  localparam int HB = 3, MEM_AW = 11, WR = 300, PG = 128, DEPTH = 1 << MEM_AW;

  logic clk = 1'b0, rst_n = 1'b0, scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe, sda_line;
  assign sda_line = sda_h & ~sda_oe;

  ee2w_target #(.MEM_AW(MEM_AW), .WR_CYCLES(WR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_line), .sda_oe_o(sda_oe));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  logic [7:0]  ref_mem [DEPTH];
  bit          ref_vld [DEPTH];
  logic [15:0] ref_ptr = 16'h0000;
  logic [7:0]  wbuf [256];
  logic [15:0] rnd_addr [8];

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ix(input logic [15:0] a);
    return int'(a[MEM_AW-1:0]);
  endfunction

  function automatic logic [15:0] pg_addr(input logic [15:0] a, input int k);
    return {a[15:7], a[6:0] + 7'(k)};
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_h = 1'b1; wt(HB); scl_h = 1'b1; wt(HB); sda_h = 1'b0; wt(HB); scl_h = 1'b0; wt(HB);
  endtask

  task automatic bus_stop;
    sda_h = 1'b0; wt(HB); scl_h = 1'b1; wt(HB); sda_h = 1'b1; wt(HB);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_h = b[7-i]; wt(HB); scl_h = 1'b1; wt(HB); scl_h = 1'b0; wt(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_h = 1'b1; wt(HB); scl_h = 1'b1; wt(1);
    ack = !sda_line;
    wt(HB - 1); scl_h = 1'b0; wt(1);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    for (int i = 7; i >= 0; i--) begin
      wt(HB); scl_h = 1'b1; wt(1); b[i] = sda_line; wt(HB - 1); scl_h = 1'b0; wt(1);
    end
    sda_h = give_ack ? 1'b0 : 1'b1;
    wt(HB); scl_h = 1'b1; wt(HB); scl_h = 1'b0; wt(1); sda_h = 1'b1;
  endtask

  task automatic wait_ready(output longint t_ack, output int polls);
    bit ack;
    polls = 0; t_ack = 0;
    for (int p = 0; p < 60; p++) begin
      bus_start; send_byte(8'hA0, ack); polls++;
      if (ack) t_ack = cyc;
      bus_stop;
      if (ack) break;
      wt(20);
    end
  endtask

  task automatic write_seq(input logic [15:0] a, input int n, input bit measure);
    bit ack; longint t_stop, t_ack; int polls;
    bus_start;
    send_byte(8'hA0, ack);     chk(ack, "R3", "write select ack", ack, 1);
    send_byte(a[15:8], ack);   chk(ack, "R4", "addr high ack", ack, 1);
    send_byte(a[7:0], ack);    chk(ack, "R4", "addr low ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); chk(ack, "R5", "data ack", ack, 1);
    end
    bus_stop; t_stop = cyc;
    for (int k = 0; k < n; k++) begin
      ref_mem[ix(pg_addr(a, k))] = wbuf[k];
      ref_vld[ix(pg_addr(a, k))] = 1'b1;
    end
    ref_ptr = (n > 0) ? pg_addr(a, n) : a;
    wait_ready(t_ack, polls);
    if (measure) begin
      chk(polls > 1, "R8", "poll refused while busy", polls, 2);
      chk(t_ack - t_stop >= WR + PG && t_ack - t_stop < WR + PG + 300,
          "R8", "busy window", t_ack - t_stop, WR + PG);
    end
    if (n == 0) chk(polls == 1, "R9", "no busy without data", polls, 1);
  endtask

  task automatic read_seq(input bit rnd, input logic [15:0] a, input int n, input string req);
    bit ack; logic [7:0] b; logic [15:0] p;
    if (rnd) begin
      bus_start;
      send_byte(8'hA0, ack);   chk(ack, "R12", "dummy write select", ack, 1);
      send_byte(a[15:8], ack); chk(ack, "R12", "addr high", ack, 1);
      send_byte(a[7:0], ack);  chk(ack, "R12", "addr low", ack, 1);
      p = a;
    end else begin
      p = ref_ptr;
    end
    bus_start;
    send_byte(8'hA1, ack); chk(ack, "R3", "read select ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k < n - 1);
      if (ref_vld[ix(p + 16'(k))])
        chk(b === ref_mem[ix(p + 16'(k))], req, "read data", b, ref_mem[ix(p + 16'(k))]);
    end
    bus_stop;
    ref_ptr = p + 16'(n);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    report;
    $finish;
  end

  initial begin
    bit ack; longint t; int polls; logic [7:0] b;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) ref_vld[i] = 1'b0;
    wt(4);
    chk(sda_oe == 1'b0, "R1", "oe in reset", sda_oe, 0);
    rst_n = 1'b1; wt(4);
    chk(sda_oe == 1'b0, "R1", "oe after reset", sda_oe, 0);

    // R3 select mismatches, R2 stop returns to idle, repeated start restarts
    bus_start; send_byte(8'hA2, ack); chk(!ack, "R3", "nak on nonzero bits", ack, 0);
    send_byte(8'hA0, ack); chk(!ack, "R3", "ignored until start", ack, 0);
    bus_start; send_byte(8'hB0, ack); chk(!ack, "R3", "nak on wrong id", ack, 0);
    bus_start; send_byte(8'hA0, ack); chk(ack, "R2", "start restarts select", ack, 1);
    send_byte(8'h12, ack);
    bus_start; send_byte(8'hA0, ack); chk(ack, "R2", "repeated start mid-address", ack, 1);
    bus_stop;
    send_byte(8'hA0, ack); chk(!ack, "R2", "no ack after stop", ack, 0);
    wt(10);

    // R5/R8 byte write with timed busy window
    wbuf[0] = 8'h5A; write_seq(16'h0123, 1, 1'b1);
    read_seq(1'b1, 16'h0123, 1, "R5");

    // R9 address-only write
    write_seq(16'h0777, 0, 1'b0);

    // R10/R12 random then current-address read
    for (int k = 0; k < 4; k++) wbuf[k] = 8'hA0 + 8'(k);
    write_seq(16'h0200, 4, 1'b0);
    read_seq(1'b1, 16'h0201, 1, "R12");
    read_seq(1'b0, 16'h0000, 1, "R10");

    // R6 page wrap past 128 bytes; next page untouched
    wbuf[0] = 8'hC3; write_seq(16'h0400, 1, 1'b0);
    for (int k = 0; k < 130; k++) wbuf[k] = 8'(k * 3 + 1);
    write_seq(16'h03FE, 130, 1'b0);
    chk(ref_ptr == 16'h0380, "R6", "model pointer", ref_ptr, 16'h0380);
    read_seq(1'b0, 16'h0000, 1, "R6");
    read_seq(1'b1, 16'h0380, 129, "R6");

    // R7 partial page keeps other bytes
    for (int k = 0; k < 128; k++) wbuf[k] = 8'(255 - k);
    write_seq(16'h0500, 128, 1'b0);
    for (int k = 0; k < 3; k++) wbuf[k] = 8'h3C + 8'(k);
    write_seq(16'h0510, 3, 1'b0);
    read_seq(1'b1, 16'h0500, 128, "R7");

    // R11 rollover 0xFFFF -> 0x0000
    wbuf[0] = 8'hE1; write_seq(16'hFFFF, 1, 1'b0);
    wbuf[0] = 8'hE2; wbuf[1] = 8'hE3; write_seq(16'h0000, 2, 1'b0);
    read_seq(1'b1, 16'hFFFF, 2, "R11");
    chk(ref_ptr == 16'h0001, "R11", "model wrap", ref_ptr, 16'h0001);
    read_seq(1'b0, 16'h0000, 1, "R11");

    // R13 stop cuts a byte: completed byte kept, partial dropped
    for (int k = 0; k < 4; k++) wbuf[k] = 8'h60 + 8'(k);
    write_seq(16'h0600, 4, 1'b0);
    bus_start; send_byte(8'hA0, ack); send_byte(8'h06, ack); send_byte(8'h00, ack);
    send_byte(8'h11, ack); send_bits(8'hFF, 3); bus_stop;
    ref_mem[ix(16'h0600)] = 8'h11; ref_ptr = 16'h0601;
    wait_ready(t, polls);
    chk(polls > 1, "R13", "busy after completed byte", polls, 2);
    read_seq(1'b1, 16'h0600, 2, "R13");

    // R13 repeated start discards staged data
    bus_start; send_byte(8'hA0, ack); send_byte(8'h06, ack); send_byte(8'h02, ack);
    send_byte(8'h77, ack);
    bus_start; send_byte(8'hA1, ack); chk(ack, "R13", "read after restart", ack, 1);
    recv_byte(b, 1'b0); bus_stop;
    chk(b === ref_mem[ix(16'h0603)], "R13", "current byte", b, ref_mem[ix(16'h0603)]);
    ref_ptr = 16'h0604;
    bus_start; send_byte(8'hA0, ack); chk(ack, "R13", "no busy after discard", ack, 1);
    bus_stop;
    read_seq(1'b1, 16'h0602, 1, "R13");

    // R1 pointer cleared, array kept
    rst_n = 1'b0; wt(3);
    chk(sda_oe == 1'b0, "R1", "oe in second reset", sda_oe, 0);
    rst_n = 1'b1; wt(3); ref_ptr = 16'h0000;
    read_seq(1'b0, 16'h0000, 1, "R1");

    // random page writes and sequential reads
    for (int w = 0; w < 8; w++) begin
      int n;
      rnd_addr[w] = 16'($urandom);
      n = 1 + int'($urandom % 64);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      write_seq(rnd_addr[w], n, 1'b0);
    end
    for (int r = 0; r < 10; r++) begin
      read_seq(1'b1, rnd_addr[$urandom % 8] + 16'($urandom % 16), 1 + int'($urandom % 24), "R11");
    end

    report;
    $finish;
  end
endmodule